// File: doc/BRIEF.md
# Beam Position Timer Interrupt

This unit raises an interrupt request when a raster beam reaches a programmed place on the screen. The beam counters arrive from outside: a dot count within the line and a line count within the frame. Software sets two 9-bit compare values and two enable bits. Together the two enables pick one of three trigger points: a chosen dot on every line, a chosen dot on one chosen line, or the first dot of one chosen line. When both enables are clear, no timer interrupt is raised.

A hit sets a sticky flag. The flag stays set until software reads the status byte. The read returns the flag in bit 7 and clears it on the following clock edge. The outgoing request line is the flag gated by a master enable.

Work-memory refresh stalls the processor for a window in each line. A hit that lands inside that window is not lost. It is held pending and delivered on the first instruction-boundary strobe after the window has closed.

Top module: `hvtimer_irq`

## Requirements
- R1: While reset is asserted and after it is released, with no hit yet, `irq_flag` is 0, `irq_req` is 0 and `stat_data` is 8'h00.
- R2: With only `h_en` set, a hit occurs on every line in the cycle where `hpos` equals `h_cmp`. The flag reads 1 from the clock edge that ends that cycle.
- R3: With `h_en` and `v_en` both set, a hit occurs only in the cycle where `hpos` equals `h_cmp` and `vpos` equals `v_cmp` at the same time.
- R4: With only `v_en` set, a hit occurs once per frame, in the cycle where `vpos` equals `v_cmp` and `hpos` is 0.
- R5: With both enables clear, no hit is taken. At the next edge the flag and any pending deferred hit are cleared.
- R6: A hit taken in a cycle with `refresh_busy` high does not set the flag. It is held pending. It sets the flag at the edge ending the first cycle in which `refresh_busy` is low and `insn_boundary` is high.
- R7: `stat_data` bit 7 shows the flag and bits 6..0 read 0. A cycle with `stat_rd` high clears the flag at its closing edge, unless a hit or delivery sets it in that same cycle, in which case the flag stays 1.
- R8: A set flag is not raised a second time and does not drop while `stat_rd` stays low and an enable is set. Further hits leave it at 1.
- R9: An `h_cmp` value greater than the last dot index `H_LAST` never produces a hit, even if `hpos` reaches that value.
- R10: `irq_req` is high exactly when the flag is set and `master_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hpos | input | 9 | Current dot count within the line |
| vpos | input | 9 | Current line count within the frame |
| h_en | input | 1 | Dot compare enable |
| v_en | input | 1 | Line compare enable |
| h_cmp | input | 9 | Dot compare value |
| v_cmp | input | 9 | Line compare value |
| master_en | input | 1 | Gate for the request line |
| refresh_busy | input | 1 | Memory-refresh stall window is active |
| insn_boundary | input | 1 | Strobe marking an instruction boundary |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| stat_data | output | 8 | Status byte, flag in bit 7 |
| irq_flag | output | 1 | Sticky timer interrupt flag |
| irq_req | output | 1 | Gated interrupt request |

## Verification
The bench aims at the deferral path. It places the dot compare inside the refresh window, so that a design which drops the hit never raises the flag, and a design which delivers it early raises the flag while the window is still open. It reads the status in the same cycle as a fresh hit; a design that lets the clear win would lose that interrupt. It drives the beam past the last dot with a compare beyond the line; a design missing that limit would fire. It switches both enables off while a flag is set; a design that keeps the flag would leave a stale request.

// File: rtl/hvtimer_pkg.sv
package hvtimer_pkg;
  typedef enum logic [1:0] {
    TM_OFF        = 2'b00,
    TM_LINE_START = 2'b01,
    TM_EVERY_LINE = 2'b10,
    TM_EXACT      = 2'b11
  } tmode_e;

  function automatic tmode_e mode_of(input logic h_on, input logic v_on);
    return tmode_e'({h_on, v_on});
  endfunction
endpackage

// File: rtl/hvtimer_match.sv
module hvtimer_match
  import hvtimer_pkg::*;
#(
  parameter int CNT_W  = 9,
  parameter int H_LAST = 339
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hpos,
  input  logic [CNT_W-1:0] vpos,
  input  logic             h_en,
  input  logic             v_en,
  input  logic [CNT_W-1:0] h_cmp,
  input  logic [CNT_W-1:0] v_cmp,
  output logic             hit,
  output logic             off
);
  localparam logic [CNT_W-1:0] HLIM = CNT_W'(H_LAST);

  tmode_e mode;
  logic   dot_eq, line_eq, home, match_now, match_q, match_d;

  always_comb begin
    mode    = mode_of(h_en, v_en);
    dot_eq  = (hpos == h_cmp) && (h_cmp <= HLIM);
    line_eq = (vpos == v_cmp);
    home    = (hpos == '0);
    unique case (mode)
      TM_EVERY_LINE: match_now = dot_eq;
      TM_EXACT:      match_now = dot_eq && line_eq;
      TM_LINE_START: match_now = line_eq && home;
      default:       match_now = 1'b0;
    endcase
    match_d = match_now;
    hit     = match_now && !match_q;
    off     = (mode == TM_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end
endmodule

// File: rtl/hvtimer_hold.sv
module hvtimer_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic off,
  input  logic refresh_busy,
  input  logic insn_boundary,
  input  logic stat_rd,
  output logic flag,
  output logic pending
);
  logic flag_d, pend_d, deliver, take_now, defer, upd_en;

  always_comb begin
    take_now = hit && !refresh_busy;
    defer    = hit && refresh_busy;
    deliver  = pending && !refresh_busy && insn_boundary;
    upd_en   = 1'b1;
    if (off) begin
      flag_d = 1'b0;
      pend_d = 1'b0;
    end else begin
      flag_d = take_now || deliver || (flag && !stat_rd);
      pend_d = defer || (pending && !deliver);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      pending <= 1'b0;
    end else if (upd_en) begin
      flag    <= flag_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/hvtimer_irq.sv
module hvtimer_irq #(
  parameter int CNT_W  = 9,
  parameter int H_LAST = 339
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hpos,
  input  logic [CNT_W-1:0] vpos,
  input  logic             h_en,
  input  logic             v_en,
  input  logic [CNT_W-1:0] h_cmp,
  input  logic [CNT_W-1:0] v_cmp,
  input  logic             master_en,
  input  logic             refresh_busy,
  input  logic             insn_boundary,
  input  logic             stat_rd,
  output logic [7:0]       stat_data,
  output logic             irq_flag,
  output logic             irq_req
);
  logic hit, off, pending;

  hvtimer_match #(.CNT_W(CNT_W), .H_LAST(H_LAST)) u_match (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .h_en(h_en), .v_en(v_en), .h_cmp(h_cmp), .v_cmp(v_cmp),
    .hit(hit), .off(off)
  );

  hvtimer_hold u_hold (
    .clk(clk), .rst_n(rst_n), .hit(hit), .off(off),
    .refresh_busy(refresh_busy), .insn_boundary(insn_boundary),
    .stat_rd(stat_rd), .flag(irq_flag), .pending(pending)
  );

  always_comb begin
    stat_data = {irq_flag, 7'b0};
    irq_req   = irq_flag && master_en;
  end
endmodule

// File: rtl/hvtimer_irq_chk.sv
module hvtimer_irq_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] hpos,
  input logic [CNT_W-1:0] h_cmp,
  input logic             h_en,
  input logic             v_en,
  input logic             master_en,
  input logic             refresh_busy,
  input logic             insn_boundary,
  input logic             stat_rd,
  input logic             irq_flag,
  input logic             irq_req,
  input logic [7:0]       stat_data
);
  a_r5_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_en && !v_en) |=> !irq_flag);

  a_r6_no_rise_in_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_busy && !irq_flag) |=> !irq_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !stat_rd && (h_en || v_en)) |=> irq_flag);

  a_r2_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && h_en && !v_en && hpos != h_cmp && !insn_boundary) |=> !irq_flag);

  a_r10_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq_req);

  a_r7_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_data[6:0] == 7'd0) && (stat_data[7] == irq_flag));
endmodule

bind hvtimer_irq hvtimer_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hpos(hpos), .h_cmp(h_cmp),
  .h_en(h_en), .v_en(v_en), .master_en(master_en),
  .refresh_busy(refresh_busy), .insn_boundary(insn_boundary),
  .stat_rd(stat_rd), .irq_flag(irq_flag), .irq_req(irq_req),
  .stat_data(stat_data)
);

// File: tb/hvtimer_irq_tb.sv
module hvtimer_irq_tb;
  localparam int PERIOD = 10;
  localparam int HLAST  = 339;
  localparam int LINES  = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [8:0] hpos, vpos, h_cmp, v_cmp;
  logic h_en, v_en, master_en, refresh_busy, insn_boundary, stat_rd;
  logic [7:0] stat_data;
  logic irq_flag, irq_req;

  always #(PERIOD/2) clk = ~clk;

  hvtimer_irq #(.CNT_W(9), .H_LAST(HLAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .h_en(h_en), .v_en(v_en), .h_cmp(h_cmp), .v_cmp(v_cmp),
    .master_en(master_en), .refresh_busy(refresh_busy),
    .insn_boundary(insn_boundary), .stat_rd(stat_rd),
    .stat_data(stat_data), .irq_flag(irq_flag), .irq_req(irq_req)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R1";

  int hcnt = 0, vcnt = 0, cyc = 0, hlen = HLAST + 1;
  bit ref_on = 0, rd_on = 0;
  int rd_dot = 300;

  // behavioural reference
  bit m_flag, m_pend, m_prev;
  function automatic bit ref_match();
    int h = hpos, v = vpos, hc = h_cmp, vc = v_cmp;
    bit dot_ok = (h == hc) && (hc <= HLAST);
    if (h_en && !v_en) return dot_ok;
    if (h_en && v_en)  return dot_ok && (v == vc);
    if (v_en)          return (v == vc) && (h == 0);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit mt, ev, nf, np;
    if (!rst_n) begin
      m_flag = 0; m_pend = 0; m_prev = 0;
    end else begin
      mt = ref_match();
      ev = mt && !m_prev;
      m_prev = mt;
      if (!h_en && !v_en) begin
        m_flag = 0; m_pend = 0;
      end else begin
        nf = m_flag && !stat_rd;
        np = m_pend;
        if (ev && !refresh_busy) nf = 1;
        if (m_pend && !refresh_busy && insn_boundary) begin nf = 1; np = 0; end
        if (ev && refresh_busy) np = 1;
        m_flag = nf; m_pend = np;
      end
    end
  end

  task automatic check(input string t, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cyc %0d: actual=%h expected=%h", t, cyc, act, exp);
    end
  endtask

  task automatic compare_now();
    check(tag, {irq_flag, irq_req, stat_data},
          {m_flag, m_flag & master_en, m_flag, 7'b0});
  endtask

  task automatic drive_beam();
    hpos          = 9'(hcnt);
    vpos          = 9'(vcnt);
    refresh_busy  = ref_on && (hcnt >= 100) && (hcnt <= 139);
    insn_boundary = (cyc % 3) == 0;
    stat_rd       = rd_on && (hcnt == rd_dot);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_now();
      cyc++;
      hcnt++;
      if (hcnt >= hlen) begin
        hcnt = 0;
        vcnt = (vcnt + 1) % LINES;
      end
      drive_beam();
    end
  endtask

  task automatic run_frame();
    step(hlen * LINES);
  endtask

  task automatic do_read();
    @(negedge clk); compare_now(); stat_rd = 1;
    @(negedge clk); compare_now(); stat_rd = 0;
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; h_en = 0; v_en = 0; h_cmp = 0; v_cmp = 0; master_en = 1;
    drive_beam();
    #(PERIOD * 3);
    // R1: reset state
    check("R1", {irq_flag, irq_req, stat_data}, 10'd0);
    @(negedge clk); rst_n = 1;
    step(5);
    check("R1", {irq_flag, irq_req, stat_data}, 10'd0);

    // R2 + R7: every-line dot compare with periodic reads
    tag = "R2"; h_en = 1; v_en = 0; h_cmp = 50; rd_on = 1; rd_dot = 300;
    run_frame();
    step(hlen - hcnt + 51);
    check("R2", {9'd0, irq_flag}, 10'd1);

    // R7: read in the same cycle as a fresh hit keeps the flag
    tag = "R7"; rd_dot = 50;
    run_frame();
    check("R7", {9'd0, stat_data[7]}, {9'd0, irq_flag});

    // R8: no reads, flag stays set across many hits
    tag = "R8"; rd_on = 0;
    run_frame();
    check("R8", {9'd0, irq_flag}, 10'd1);

    // R5: both enables cleared drops flag
    tag = "R5"; h_en = 0; v_en = 0;
    step(3);
    check("R5", {9'd0, irq_flag}, 10'd0);
    run_frame();

    // R3: exact position, with master gate toggled (R10)
    tag = "R3"; h_en = 1; v_en = 1; h_cmp = 60; v_cmp = 5; rd_on = 1; rd_dot = 200;
    run_frame();
    tag = "R10"; master_en = 0;
    run_frame();
    check("R10", {9'd0, irq_req}, 10'd0);
    master_en = 1;

    // R4: line-start mode
    tag = "R4"; h_en = 0; v_en = 1; v_cmp = 3; rd_dot = 170;
    run_frame();
    run_frame();

    // R6: hit inside refresh window is deferred
    tag = "R6"; h_en = 1; v_en = 0; h_cmp = 120; ref_on = 1; rd_dot = 300;
    run_frame();
    while (hcnt != 125) step(1);
    check("R6", {9'd0, irq_flag}, 10'd0);
    while (hcnt != 145) step(1);
    check("R6", {9'd0, irq_flag}, 10'd1);
    do_read();
    // R5: pending cleared by disabling during window
    tag = "R5";
    while (hcnt != 130) step(1);
    h_en = 0; step(2); h_en = 1;
    while (hcnt != 200) step(1);
    check("R5", {9'd0, irq_flag}, 10'd0);
    ref_on = 0;

    // R9: compare beyond last dot never fires, beam driven past it
    tag = "R9"; h_cmp = 400; hlen = 512; rd_dot = 10;
    run_frame();
    check("R9", {9'd0, irq_flag}, 10'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule